// File: doc/BRIEF.md
# Single-Channel Bus-Mastering Transfer Engine

This block moves a run of words between one peripheral and system memory without the processor touching each word. Software programs four values through a small register port: the direction, a fixed peripheral address, a starting memory address and a word count. Software then sets the start bit. The engine raises a request on the shared system bus. It touches memory only while the bus arbiter grants it the bus, and it moves words one at a time. Each word is read from its source and written to its destination, so memory sees exactly one access per word. The peripheral sits on a private port of the engine.

The processor always wins the bus. After every word the engine checks the processor's request line. If that line is high, the engine drops its own request for a cycle so the processor can take the bus, then asks again. When the last word has been written, the engine raises an interrupt. The interrupt stays high until software clears it. While a transfer runs, the programming registers cannot be changed. Software can still read them to watch the live memory address, the remaining count and a busy flag.

Top module: `dma_engine`

## Requirements
- R1: After synchronous reset all four registers read back zero, `bus_req` is low and `irq` is low.
- R2: Register offsets on `reg_addr` are: 0 control/status, 1 peripheral address, 2 memory address, 3 word count. Control write bits: bit 0 starts, bit 1 picks direction (0 = peripheral to memory, 1 = memory to peripheral), bit 2 clears the interrupt. Status read bits: bit 0 busy, bit 1 interrupt, bit 2 direction. Busy reads 1 from the cycle after a start until the transfer completes.
- R3: A start with a nonzero count raises `bus_req` in the next cycle. No memory strobe (`mem_rd`, `mem_wr`) is ever driven while `bus_gnt` is low.
- R4: In peripheral-to-memory mode each word is one `dev_rd` followed by one `mem_wr` carrying that word. Memory sees exactly one access per word, and at most one strobe is active in any cycle.
- R5: In memory-to-peripheral mode each word is one `mem_rd` followed by one `dev_wr` carrying that word.
- R6: The memory address advances by one after each word. `dev_addr` stays at the programmed value for the whole transfer.
- R7: The count register drops by one per word and reads 0 at the end. `irq` rises in the cycle right after the final write strobe.
- R8: If `cpu_req` is high in the write cycle of a word that is not the last, `bus_req` goes low in the next cycle and is raised again one cycle later. If `cpu_req` stays low, the request is held across words.
- R9: Once high, `irq` stays high until a control write with bit 2 set, or a new start, clears it.
- R10: A start with a count of zero raises `irq` in the next cycle and never raises `bus_req`.
- R11: While busy, writes to any register are ignored. This includes a second start and a clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for `reg_addr` (combinational) |
| cpu_req | input | 1 | Processor is asking for the bus |
| bus_req | output | 1 | Engine bus request |
| bus_gnt | input | 1 | Bus granted to the engine |
| mem_addr | output | AW | Memory word address |
| mem_rd | output | 1 | Memory read strobe, data returned in the same cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| dev_addr | output | AW | Peripheral address |
| dev_rd | output | 1 | Peripheral read strobe, data returned in the same cycle |
| dev_wr | output | 1 | Peripheral write strobe |
| dev_wdata | output | DW | Peripheral write data |
| dev_rdata | input | DW | Peripheral read data |
| irq | output | 1 | Completion interrupt |

## Verification
Faults in the sequencer state show up at the ports within one word time:
- A skipped fetch or a stale data buffer puts a wrong word into memory or into the peripheral log.
- A missed yield leaves `bus_req` high through a cycle where the processor had asked.

Faults in the address or count registers show up by the end of a transfer:
- A wrong memory address or count shows in the read-back.
- A wrong count shifts the interrupt away from the cycle after the last write.

Lock faults are exposed by writes made mid-transfer and the read-backs that follow.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_DEV  = 2'd1;
    localparam logic [1:0] RA_MEM  = 2'd2;
    localparam logic [1:0] RA_CNT  = 2'd3;

    localparam int CB_GO   = 0;
    localparam int CB_DIR  = 1;
    localparam int CB_CLR  = 2;

    localparam int SB_BUSY = 0;
    localparam int SB_IRQ  = 1;
    localparam int SB_DIR  = 2;

    typedef enum logic {
        DIR_DEV2MEM = 1'b0,
        DIR_MEM2DEV = 1'b1
    } dma_dir_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_FETCH,
        ST_PUT,
        ST_YIELD
    } dma_state_e;

    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic dev_rd;
        logic dev_wr;
    } dma_strb_t;

    // Source read in the fetch phase, destination write in the put phase.
    function automatic dma_strb_t route(input dma_dir_e dir, input logic fetch, input logic put);
        dma_strb_t s;
        s.dev_rd = fetch && (dir == DIR_DEV2MEM);
        s.mem_rd = fetch && (dir == DIR_MEM2DEV);
        s.mem_wr = put   && (dir == DIR_DEV2MEM);
        s.dev_wr = put   && (dir == DIR_MEM2DEV);
        return s;
    endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          busy,
    input  logic          step,
    input  logic          finish,
    output logic          go,
    output dma_dir_e      dir,
    output logic [AW-1:0] dev_addr,
    output logic [AW-1:0] mem_addr,
    output logic [CW-1:0] count,
    output logic          irq
);

    logic          acc;
    logic          clr_irq;
    logic          wdata_unused;
    dma_dir_e      dir_q;
    logic [AW-1:0] dev_q;
    logic [AW-1:0] mem_q;
    logic [CW-1:0] cnt_q;
    logic          irq_q;

    assign wdata_unused = ^reg_wdata;
    assign acc     = reg_wr && !busy;
    assign go      = acc && (reg_addr == RA_CTRL) && reg_wdata[CB_GO];
    assign clr_irq = acc && (reg_addr == RA_CTRL) && (reg_wdata[CB_CLR] || reg_wdata[CB_GO]);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= DIR_DEV2MEM;
            dev_q <= '0;
            mem_q <= '0;
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            if (acc) begin
                unique case (reg_addr)
                    RA_CTRL: dir_q <= dma_dir_e'(reg_wdata[CB_DIR]);
                    RA_DEV:  dev_q <= reg_wdata[AW-1:0];
                    RA_MEM:  mem_q <= reg_wdata[AW-1:0];
                    RA_CNT:  cnt_q <= reg_wdata[CW-1:0];
                    default: ;
                endcase
            end
            if (step) begin
                mem_q <= mem_q + AW'(1);
                cnt_q <= cnt_q - CW'(1);
            end
            if (finish)
                irq_q <= 1'b1;
            else if (clr_irq)
                irq_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_CTRL: begin
                reg_rdata[SB_BUSY] = busy;
                reg_rdata[SB_IRQ]  = irq_q;
                reg_rdata[SB_DIR]  = dir_q;
            end
            RA_DEV:  reg_rdata = DW'(dev_q);
            RA_MEM:  reg_rdata = DW'(mem_q);
            RA_CNT:  reg_rdata = DW'(cnt_q);
            default: ;
        endcase
    end

    assign dir      = dir_q;
    assign dev_addr = dev_q;
    assign mem_addr = mem_q;
    assign count    = cnt_q;
    assign irq      = irq_q;

    // R7: every word consumes exactly one count
    p_count_step_r7: assert property (@(posedge clk) disable iff (rst)
        step |=> (cnt_q == $past(cnt_q) - CW'(1)));

    // R6: memory address walks forward one word per transfer
    p_mem_step_r6: assert property (@(posedge clk) disable iff (rst)
        step |=> (mem_q == $past(mem_q) + AW'(1)));

    // R11: programming is frozen while a transfer runs
    p_locked_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && reg_wr) |=> ($stable(dev_q) && $stable(dir_q)));

    // R9: interrupt is sticky until an accepted clear or start
    p_irq_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !(reg_wr && !busy && reg_addr == RA_CTRL && (reg_wdata[CB_CLR] || reg_wdata[CB_GO])))
        |=> irq_q);

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  dma_dir_e      dir,
    input  logic [CW-1:0] count,
    input  logic          cpu_req,
    input  logic          bus_gnt,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] dev_rdata,
    output logic          bus_req,
    output logic          busy,
    output logic          step,
    output logic          finish,
    output dma_strb_t     strb,
    output logic [DW-1:0] data_buf
);

    dma_state_e    state_q;
    dma_state_e    state_d;
    logic [DW-1:0] buf_q;
    logic          last;

    assign last = (count == CW'(1));

    always_comb begin
        state_d = state_q;
        bus_req = 1'b0;
        step    = 1'b0;
        finish  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (go) begin
                    if (count == '0) finish  = 1'b1;
                    else             state_d = ST_REQ;
                end
            end
            ST_REQ: begin
                bus_req = 1'b1;
                if (bus_gnt) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                bus_req = 1'b1;
                state_d = ST_PUT;
            end
            ST_PUT: begin
                bus_req = 1'b1;
                step    = 1'b1;
                if (last) begin
                    finish  = 1'b1;
                    state_d = ST_IDLE;
                end else if (cpu_req) begin
                    state_d = ST_YIELD;
                end else begin
                    state_d = ST_FETCH;
                end
            end
            ST_YIELD: state_d = ST_REQ;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            buf_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FETCH)
                buf_q <= (dir == DIR_MEM2DEV) ? mem_rdata : dev_rdata;
        end
    end

    assign strb     = route(dir, state_q == ST_FETCH, state_q == ST_PUT);
    assign busy     = (state_q != ST_IDLE);
    assign data_buf = buf_q;

    // R3: memory is only touched under grant
    p_grant_r3: assert property (@(posedge clk) disable iff (rst)
        (strb.mem_rd || strb.mem_wr) |-> bus_gnt);

    // R4: never more than one strobe per cycle
    p_one_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({strb.mem_rd, strb.mem_wr, strb.dev_rd, strb.dev_wr}));

    // R4: a fetch is always followed by its put
    p_fetch_put_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FETCH) |=> (state_q == ST_PUT));

    // R8: processor request forces a release between words
    p_yield_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PUT && cpu_req && !last) |=> !bus_req);

    // R10: empty transfer stays off the bus
    p_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && go && count == '0) |=> (state_q == ST_IDLE && !bus_req));

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          cpu_req,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] dev_addr,
    output logic          dev_rd,
    output logic          dev_wr,
    output logic [DW-1:0] dev_wdata,
    input  logic [DW-1:0] dev_rdata,
    output logic          irq
);

    logic          busy;
    logic          step;
    logic          finish;
    logic          go;
    dma_dir_e      dir;
    logic [CW-1:0] count;
    dma_strb_t     strb;
    logic [DW-1:0] data_buf;

    dma_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .step      (step),
        .finish    (finish),
        .go        (go),
        .dir       (dir),
        .dev_addr  (dev_addr),
        .mem_addr  (mem_addr),
        .count     (count),
        .irq       (irq)
    );

    dma_seq #(.DW(DW), .CW(CW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .dir       (dir),
        .count     (count),
        .cpu_req   (cpu_req),
        .bus_gnt   (bus_gnt),
        .mem_rdata (mem_rdata),
        .dev_rdata (dev_rdata),
        .bus_req   (bus_req),
        .busy      (busy),
        .step      (step),
        .finish    (finish),
        .strb      (strb),
        .data_buf  (data_buf)
    );

    assign mem_rd    = strb.mem_rd;
    assign mem_wr    = strb.mem_wr;
    assign dev_rd    = strb.dev_rd;
    assign dev_wr    = strb.dev_wr;
    assign mem_wdata = data_buf;
    assign dev_wdata = data_buf;

endmodule

// File: tb/dma_engine_tb.sv
`timescale 1ns/1ps
module dma_engine_tb;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int CW = 16;

    typedef struct packed {
        logic        dir;
        logic        cpu;
        logic [15:0] dev;
        logic [15:0] mem;
        logic [15:0] cnt;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 16'h0040, 16'd4,  16'd5},
        '{1'b1, 1'b0, 16'h0123, 16'd20, 16'd6},
        '{1'b0, 1'b1, 16'h0BEE, 16'd40, 16'd4},
        '{1'b1, 1'b1, 16'h0777, 16'd50, 16'd7},
        '{1'b0, 1'b0, 16'h0009, 16'd60, 16'd1}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          cpu_req;
    logic          bus_req;
    logic          bus_gnt;
    logic [AW-1:0] mem_addr;
    logic          mem_rd, mem_wr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic [AW-1:0] dev_addr;
    logic          dev_rd, dev_wr;
    logic [DW-1:0] dev_wdata, dev_rdata;
    logic          irq;

    always #2 clk = ~clk;

    dma_engine #(.AW(AW), .DW(DW), .CW(CW)) u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_req(cpu_req),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .dev_addr(dev_addr), .dev_rd(dev_rd),
        .dev_wr(dev_wr), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .irq(irq)
    );

    // ---------------- environment models ----------------
    logic        cpu_mode = 1'b0;
    logic [15:0] exp_dev  = '0;
    int          cyc = 0;
    logic        gnt_q = 1'b0;
    int          dev_rd_n = 0, dlog_n = 0, mem_acc_n = 0;
    int          nogrant_n = 0, devaddr_n = 0, multi_n = 0, req_cyc_n = 0, yield_n = 0;
    int          last_wr_cyc = 0;
    logic        prev_req = 1'b0;
    logic [DW-1:0] wmem [64];
    logic [DW-1:0] dlog [64];

    function automatic logic [DW-1:0] pre(input logic [15:0] a);
        return 32'h5A00_0000 | (32'(a) * 32'd7);
    endfunction

    assign cpu_req   = cpu_mode && (cyc[1:0] != 2'd0);
    assign bus_gnt   = gnt_q;
    assign mem_rdata = pre(mem_addr);
    assign dev_rdata = {8'hC3, 8'(dev_rd_n), dev_addr};

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) gnt_q <= 1'b0;
        else     gnt_q <= bus_req && (gnt_q || !cpu_req);
        if (mem_wr) wmem[mem_addr[5:0]] <= mem_wdata;
        if (dev_wr) begin
            dlog[dlog_n[5:0]] <= dev_wdata;
            dlog_n <= dlog_n + 1;
        end
        if (dev_rd) dev_rd_n <= dev_rd_n + 1;
        if (mem_rd || mem_wr) mem_acc_n <= mem_acc_n + 1;
        if ((mem_rd || mem_wr) && !bus_gnt) nogrant_n <= nogrant_n + 1;
        if ((dev_rd || dev_wr) && dev_addr != exp_dev) devaddr_n <= devaddr_n + 1;
        if ($countones({mem_rd, mem_wr, dev_rd, dev_wr}) > 1) multi_n <= multi_n + 1;
        if (bus_req) req_cyc_n <= req_cyc_n + 1;
        if (mem_wr || dev_wr) last_wr_cyc <= cyc;
        if (!rst && prev_req && !bus_req && !irq) yield_n <= yield_n + 1;
        prev_req <= bus_req;
    end

    // ---------------- check machinery ----------------
    int errors = 0;
    int checks = 0;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic wait_irq(output logic ok);
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (irq) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog act=1 exp=0");
        $display("  Result: errors=%0d of %0d checks", errors + 1, checks + 1);
        $finish;
    end

    task automatic run_case(input vec_t v);
        logic [31:0] d;
        logic ok;
        int rd0, log0, acc0, y0, bad;
        logic [31:0] e, a;
        cpu_mode = v.cpu;
        exp_dev  = v.dev;
        wr(2'd1, 32'(v.dev));
        wr(2'd2, 32'(v.mem));
        wr(2'd3, 32'(v.cnt));
        rd0 = dev_rd_n; log0 = dlog_n; acc0 = mem_acc_n; y0 = yield_n;
        wr(2'd0, 32'h1 | (32'(v.dir) << 1));
        rd(2'd0, d);
        chk(d[0] == 1'b1 && irq == 1'b0, "R2 busy after start", d, 32'h1);
        chk(bus_req == 1'b1, "R3 bus_req after start", 32'(bus_req), 1);
        wait_irq(ok);
        chk(ok, "R7 completion irq", 32'(ok), 1);
        chk(cyc == last_wr_cyc + 1, "R7 irq timing", cyc, last_wr_cyc + 1);
        rd(2'd3, d);
        chk(d == 0, "R7 count readback", d, 0);
        rd(2'd2, d);
        chk(d == 32'(16'(v.mem + v.cnt)), "R6 mem address advance", d, 32'(16'(v.mem + v.cnt)));
        rd(2'd1, d);
        chk(d == 32'(v.dev), "R6 dev address fixed", d, 32'(v.dev));
        rd(2'd0, d);
        chk(d[2:0] == {v.dir, 2'b10}, "R2 status after done", d, {v.dir, 2'b10});
        chk(mem_acc_n - acc0 == int'(v.cnt), "R4 one memory access per word", mem_acc_n - acc0, v.cnt);
        bad = 0;
        for (int i = 0; i < int'(v.cnt); i++) begin
            if (!v.dir) begin
                e = {8'hC3, 8'(rd0 + i), v.dev};
                a = wmem[6'(int'(v.mem) + i)];
            end else begin
                e = pre(16'(int'(v.mem) + i));
                a = dlog[6'(log0 + i)];
            end
            if (a !== e) bad++;
        end
        if (!v.dir) chk(bad == 0, "R4 peripheral to memory data", bad, 0);
        else        chk(bad == 0, "R5 memory to peripheral data", bad, 0);
        chk(yield_n - y0 == (v.cpu ? int'(v.cnt) - 1 : 0), "R8 yield count",
            yield_n - y0, v.cpu ? int'(v.cnt) - 1 : 0);
    endtask

    initial begin : main
        logic [31:0] d;
        logic ok;
        int r0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int k = 0; k < 4; k++) begin
            rd(2'(k), d);
            chk(d == 0, "R1 register reset", d, 0);
        end
        chk(bus_req == 1'b0 && irq == 1'b0, "R1 outputs idle", {bus_req, irq}, 0);

        // table-driven transfers
        for (int n = 0; n < NV; n++) begin
            run_case(VECS[n]);
            if (n == 0) begin
                repeat (10) @(negedge clk);
                chk(irq == 1'b1, "R9 irq held", 32'(irq), 1);
            end
            wr(2'd0, 32'h4);
            chk(irq == 1'b0, "R9 irq cleared", 32'(irq), 0);
        end

        // R10 zero count
        cpu_mode = 1'b0;
        wr(2'd3, 32'd0);
        r0 = req_cyc_n;
        wr(2'd0, 32'h1);
        chk(irq == 1'b1, "R10 zero count irq", 32'(irq), 1);
        repeat (5) @(negedge clk);
        chk(req_cyc_n == r0, "R10 no bus request", req_cyc_n - r0, 0);
        rd(2'd0, d);
        chk(d[0] == 1'b0, "R10 not busy", d, 32'h2);

        // R9 start clears irq, R11 writes ignored while busy
        cpu_mode = 1'b1;
        exp_dev  = 16'h0321;
        wr(2'd1, 32'h0321);
        wr(2'd2, 32'd10);
        wr(2'd3, 32'd6);
        wr(2'd0, 32'h1);
        chk(irq == 1'b0, "R9 start clears irq", 32'(irq), 0);
        wr(2'd1, 32'hFFFF);
        wr(2'd3, 32'h99);
        wr(2'd0, 32'h7);
        rd(2'd0, d);
        chk(d[0] == 1'b1 && d[2] == 1'b0, "R11 still busy, direction kept", d, 32'h1);
        rd(2'd1, d);
        chk(d == 32'h0321, "R11 dev write ignored", d, 32'h0321);
        wait_irq(ok);
        chk(ok, "R11 transfer completes", 32'(ok), 1);
        rd(2'd2, d);
        chk(d == 32'd16, "R11 count write ignored", d, 16);
        cpu_mode = 1'b0;

        chk(nogrant_n == 0, "R3 memory strobe without grant", nogrant_n, 0);
        chk(devaddr_n == 0, "R6 dev address moved", devaddr_n, 0);
        chk(multi_n == 0, "R4 overlapping strobes", multi_n, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule